// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit holds the interrupt and line-status state of a 16550-style UART. A host reaches it through a byte-wide register port with a 3-bit address and separate read and write strobes. The unit takes condition inputs from the receiver and transmitter paths: the receive FIFO fill count, error pulses, holding-register and shifter idle levels, a receive-timeout level and a modem-change level. From these it keeps an interrupt enable register, the FIFO mode and trigger selection, a line status byte with sticky error bits, and a prioritised identification code. It drives a single active-high interrupt request.

Reading a register has side effects. A line-status read clears the sticky errors. An identification read that reports the transmit-empty source retires that source. A change of FIFO mode clears both FIFOs and arms the transmit-empty source again. The serial shifters, the FIFO storage and the baud generator lie outside the unit. Address 0 reads return zero here, because the receive data path supplies that byte elsewhere.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset the enable register (address 1) reads 0x00, the identification register (address 2) reads 0x01 and `irq` is low. With `rx_count` = 0 and both transmitter idle inputs high, the line status register (address 5) reads 0x60.
- R2: A write to address 1 stores bits 3:0 and reads back with bits 7:4 as zero. Bit 0 enables received-data and timeout, bit 1 enables transmit-empty, bit 2 enables line-status and bit 3 enables the modem source.
- R3: The line status byte has these fields. Bit 0 is `rx_count` ≠ 0. Bits 1 to 4 are sticky flags for overrun, parity, framing and break. Bit 5 is `thr_empty` and bit 6 is `tx_empty`. Bit 7 is set by a parity, framing or break event while FIFO mode is on. One framing error in FIFO mode with one byte held, and the shifter busy, reads 0xA9.
- R4: A read of address 5 clears bits 1 to 4 and bit 7 at that clock edge, so the line-status interrupt is gone in the next cycle.
- R5: Pending sources are ranked highest first: line status (code 0x6), received data (0x4), receive timeout (0xC), transmit-empty (0x2), modem (0x0). Identification bits 3:0 carry the code of the highest enabled pending source.
- R6: Identification bits 7:6 read 11 while FIFO mode is on and 00 otherwise. Bit 0 reads 1 exactly when no enabled source is pending, and `irq` is then low.
- R7: The transmit-empty source is retired by a read of address 2 that reports it (code 0x2), or by a write to address 0.
- R8: A write to address 1 that sets bit 1 from 0 while `thr_empty` is high raises the transmit-empty interrupt in the next cycle.
- R9: A write to address 2 whose bit 0 differs from the current FIFO mode pulses both FIFO clear outputs and, if `thr_empty` is high, arms the transmit-empty source, in either direction. A write with an unchanged bit 0 arms nothing.
- R10: A write to address 2 that turns FIFO mode off clears bits 1 to 4 and bit 7 of the line status byte, so the line-status interrupt is gone in the next cycle.
- R11: Bits 7:6 of a write to address 2 select the receive trigger: 00 selects 1 byte, 01 selects DEPTH/4, 10 selects DEPTH/2 and 11 selects DEPTH-2. In FIFO mode received data is pending when `rx_count` ≥ trigger; otherwise it is pending when `rx_count` ≠ 0.
- R12: Bit 1 of a write to address 2 pulses `rx_fifo_clr` and bit 2 pulses `tx_fifo_clr`, each for one cycle after the write edge.
- R13: The receive-timeout source counts only in FIFO mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| rx_count | input | CNT_W | Bytes held in the receive FIFO or holding register |
| thr_empty | input | 1 | Transmit holding register or FIFO empty |
| tx_empty | input | 1 | Transmit shifter idle and holding empty |
| rx_timeout | input | 1 | Receive character timeout condition |
| modem_event | input | 1 | Modem status change pending |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_parity_err | input | 1 | Parity error event pulse |
| ev_frame_err | input | 1 | Framing error event pulse |
| ev_break | input | 1 | Break event pulse |
| irq | output | 1 | Interrupt request, active high |
| fifo_mode | output | 1 | FIFO mode enabled |
| rx_trig_sel | output | 2 | Selected receive trigger field |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |

## Verification
The bench builds the unit with FIFO_DEPTH = 16, so the four trigger settings are 1, 4, 8 and 14 bytes. A 5-bit `rx_count` can then sit just under and exactly at each threshold. It also steps down through every source in rank order by retiring them one at a time, which reaches each identification code in FIFO mode.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt identification unit.
// Assumes a 3-bit register address space; only the offsets below decode.
package uart_irq_pkg;
    localparam logic [2:0] ADDR_DATA  = 3'd0;
    localparam logic [2:0] ADDR_IEN   = 3'd1;
    localparam logic [2:0] ADDR_IDENT = 3'd2;
    localparam logic [2:0] ADDR_LSTAT = 3'd5;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_TXEMPTY = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_RXTMO   = 4'hC
    } iid_e;

    // Receive trigger threshold in bytes for a given select field.
    function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_cfg.sv
// Holds the interrupt enable bits and the FIFO control fields.
// Derives single-cycle events for FIFO mode changes and FIFO clears.
// Assumes write strobes are already decoded by address.
module uart_irq_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ien,
    input  logic       wr_fctl,
    input  logic [7:0] wdata,
    output logic [3:0] ien,
    output logic       fifo_on,
    output logic [1:0] trig_sel,
    output logic       fifo_flip,
    output logic       fifo_off_now,
    output logic       thre_en_rise,
    output logic       rx_clr,
    output logic       tx_clr
);
    // Same-cycle events seen by the other blocks at the write edge.
    always_comb begin
        fifo_flip    = wr_fctl && (wdata[0] != fifo_on);
        fifo_off_now = fifo_flip && !wdata[0];
        thre_en_rise = wr_ien && wdata[1] && !ien[1];
    end

    // Register storage for enables and FIFO control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien      <= '0;
            fifo_on  <= 1'b0;
            trig_sel <= 2'b00;
        end else begin
            if (wr_ien)
                ien <= wdata[3:0];
            if (wr_fctl) begin
                fifo_on  <= wdata[0];
                trig_sel <= wdata[7:6];
            end
        end
    end

    // One-cycle clear strobes, also raised on a FIFO mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_clr <= 1'b0;
            tx_clr <= 1'b0;
        end else begin
            rx_clr <= wr_fctl && (wdata[1] || fifo_flip);
            tx_clr <= wr_fctl && (wdata[2] || fifo_flip);
        end
    end

    a_r2_ien_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ien |=> $stable(ien));
    a_r12_rx_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fctl && wdata[1]) |=> rx_clr);
    a_r12_tx_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fctl && wdata[2]) |=> tx_clr);
    a_r9_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flip |=> (rx_clr && tx_clr));
endmodule

// File: rtl/uart_irq_lsr.sv
// Line status byte: live receiver and transmitter levels plus sticky errors.
// Sticky bits clear on a status read or when FIFO mode is turned off.
// A new event in the clearing cycle is kept.
module uart_irq_lsr #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_overrun,
    input  logic             ev_parity,
    input  logic             ev_frame,
    input  logic             ev_break,
    input  logic             thr_empty,
    input  logic             tx_empty,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             fifo_on,
    input  logic             fifo_off_now,
    input  logic             lsr_rd,
    output logic [7:0]       lsr,
    output logic             ls_active
);
    logic [3:0] err_q;      // {break, framing, parity, overrun}
    logic       fifo_err_q;
    logic [3:0] new_ev;
    logic       clr;

    // Gather this cycle's events and the clear condition.
    always_comb begin
        new_ev = {ev_break, ev_frame, ev_parity, ev_overrun};
        clr    = lsr_rd || fifo_off_now;
    end

    // Sticky error flags: set by events, cleared by read or FIFO off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= '0;
            fifo_err_q <= 1'b0;
        end else begin
            err_q      <= (clr ? 4'b0 : err_q) | new_ev;
            fifo_err_q <= (clr ? 1'b0 : fifo_err_q) | (fifo_on && |new_ev[3:1]);
        end
    end

    // Assemble the status byte.
    always_comb begin
        lsr       = {fifo_err_q, tx_empty, thr_empty, err_q, (rx_count != '0)};
        ls_active = |err_q;
    end

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && new_ev == 4'b0) |=> (lsr[4:1] == 4'b0 && !lsr[7]));
    a_r10_fifo_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_off_now && new_ev == 4'b0) |=> !ls_active);
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |=> lsr[3]);
endmodule

// File: rtl/uart_irq_thre.sv
// Pending flag for the transmit-empty interrupt source.
// Armed on a rising thr_empty, on enabling the source while empty, or on a
// FIFO mode change while empty; retired by an identification read that
// reports it, by a data write, or when the holding register fills.
module uart_irq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic iid_rd_thre,
    input  logic thre_en_rise,
    input  logic fifo_flip,
    output logic pend
);
    logic prev_q;
    logic set;
    logic clr;

    // Arm and retire conditions.
    always_comb begin
        set = thr_empty && (!prev_q || thre_en_rise || fifo_flip);
        clr = thr_wr || iid_rd_thre || !thr_empty;
    end

    // Edge history and pending flag; arming wins over retiring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_q <= thr_empty;
            if (set)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    a_r7_ident_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd_thre && prev_q && !thre_en_rise && !fifo_flip) |=> !pend);
    a_r8_enable_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_en_rise && thr_empty) |=> pend);
    a_r9_flip_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flip && thr_empty) |=> pend);
endmodule

// File: rtl/uart_irq_prio.sv
// Qualifies each interrupt source with its enable and picks the highest.
// Pure combinational path; clock and reset are used only by the checks.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ien,
    input  logic             ls_active,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_on,
    input  logic             rx_tmo,
    input  logic             thre_pend,
    input  logic             modem,
    output iid_e             iid,
    output logic             irq
);
    logic [CNT_W-1:0] level;
    logic src_ls, src_rd, src_to, src_te, src_mo;

    // Enabled source conditions.
    always_comb begin
        level  = CNT_W'(trig_bytes(trig_sel, FIFO_DEPTH));
        src_ls = ien[2] && ls_active;
        src_rd = ien[0] && (fifo_on ? (rx_count >= level) : (rx_count != '0));
        src_to = ien[0] && fifo_on && rx_tmo;
        src_te = ien[1] && thre_pend;
        src_mo = ien[3] && modem;
        irq    = src_ls || src_rd || src_to || src_te || src_mo;
    end

    // Fixed-rank selection of the reported code.
    always_comb begin
        if (src_ls)      iid = IID_LINE;
        else if (src_rd) iid = IID_RXDATA;
        else if (src_to) iid = IID_RXTMO;
        else if (src_te) iid = IID_TXEMPTY;
        else if (src_mo) iid = IID_MODEM;
        else             iid = IID_NONE;
    end

    a_r5_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        src_ls |-> (iid == IID_LINE));
    a_r6_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iid == IID_NONE));
    a_r13_tmo_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (iid != IID_RXTMO));
endmodule

// File: rtl/uart_irq_ident.sv
// Top of the UART interrupt identification unit: decodes register accesses,
// ties the configuration, line-status, transmit-empty and priority blocks
// together, and muxes read data. Reads are combinational; their side effects
// take place at the clock edge when reg_rd is high.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             thr_empty,
    input  logic             tx_empty,
    input  logic             rx_timeout,
    input  logic             modem_event,
    input  logic             ev_overrun,
    input  logic             ev_parity_err,
    input  logic             ev_frame_err,
    input  logic             ev_break,
    output logic             irq,
    output logic             fifo_mode,
    output logic [1:0]       rx_trig_sel,
    output logic             rx_fifo_clr,
    output logic             tx_fifo_clr
);
    logic       wr_data, wr_ien, wr_fctl, rd_ident, rd_lstat, iid_rd_thre;
    logic [3:0] ien;
    logic       fifo_flip, fifo_off_now, thre_en_rise;
    logic [7:0] lsr;
    logic       ls_active, thre_pend;
    iid_e       iid;
    logic [7:0] ident;

    // Address decode of the access strobes.
    always_comb begin
        wr_data     = reg_wr && (reg_addr == ADDR_DATA);
        wr_ien      = reg_wr && (reg_addr == ADDR_IEN);
        wr_fctl     = reg_wr && (reg_addr == ADDR_IDENT);
        rd_ident    = reg_rd && (reg_addr == ADDR_IDENT);
        rd_lstat    = reg_rd && (reg_addr == ADDR_LSTAT);
        iid_rd_thre = rd_ident && (iid == IID_TXEMPTY);
    end

    uart_irq_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ien       (wr_ien),
        .wr_fctl      (wr_fctl),
        .wdata        (reg_wdata),
        .ien          (ien),
        .fifo_on      (fifo_mode),
        .trig_sel     (rx_trig_sel),
        .fifo_flip    (fifo_flip),
        .fifo_off_now (fifo_off_now),
        .thre_en_rise (thre_en_rise),
        .rx_clr       (rx_fifo_clr),
        .tx_clr       (tx_fifo_clr)
    );

    uart_irq_lsr #(.CNT_W(CNT_W)) u_lsr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_overrun   (ev_overrun),
        .ev_parity    (ev_parity_err),
        .ev_frame     (ev_frame_err),
        .ev_break     (ev_break),
        .thr_empty    (thr_empty),
        .tx_empty     (tx_empty),
        .rx_count     (rx_count),
        .fifo_on      (fifo_mode),
        .fifo_off_now (fifo_off_now),
        .lsr_rd       (rd_lstat),
        .lsr          (lsr),
        .ls_active    (ls_active)
    );

    uart_irq_thre u_thre (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_empty    (thr_empty),
        .thr_wr       (wr_data),
        .iid_rd_thre  (iid_rd_thre),
        .thre_en_rise (thre_en_rise),
        .fifo_flip    (fifo_flip),
        .pend         (thre_pend)
    );

    uart_irq_prio #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien       (ien),
        .ls_active (ls_active),
        .rx_count  (rx_count),
        .trig_sel  (rx_trig_sel),
        .fifo_on   (fifo_mode),
        .rx_tmo    (rx_timeout),
        .thre_pend (thre_pend),
        .modem     (modem_event),
        .iid       (iid),
        .irq       (irq)
    );

    // Read data selection; the receive data byte is supplied elsewhere.
    always_comb begin
        ident = {fifo_mode, fifo_mode, 2'b00, iid};
        case (reg_addr)
            ADDR_IEN:   reg_rdata = {4'b0000, ien};
            ADDR_IDENT: reg_rdata = ident;
            ADDR_LSTAT: reg_rdata = lsr;
            default:    reg_rdata = 8'h00;
        endcase
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ien == 4'b0 && !irq && !fifo_mode));
    a_r6_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ident[7:6] == {2{fifo_mode}}) && (ident[0] == !irq));
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [CW-1:0] rx_count = '0;
    logic          thr_empty = 1'b1, tx_empty = 1'b1;
    logic          rx_timeout = 1'b0, modem_event = 1'b0;
    logic          ev_overrun = 1'b0, ev_parity_err = 1'b0;
    logic          ev_frame_err = 1'b0, ev_break = 1'b0;
    logic          irq, fifo_mode, rx_fifo_clr, tx_fifo_clr;
    logic [1:0]    rx_trig_sel;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;  // 50 MHz

    uart_irq_ident #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_count(rx_count), .thr_empty(thr_empty), .tx_empty(tx_empty),
        .rx_timeout(rx_timeout), .modem_event(modem_event),
        .ev_overrun(ev_overrun), .ev_parity_err(ev_parity_err),
        .ev_frame_err(ev_frame_err), .ev_break(ev_break), .irq(irq),
        .fifo_mode(fifo_mode), .rx_trig_sel(rx_trig_sel),
        .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr)
    );

    typedef struct packed {
        logic [1:0] op;    // 0 idle, 1 write, 2 read
        logic [2:0] addr;
        logic [7:0] wd;
        logic [4:0] rxc;
        logic [7:0] exp;   // expected read data
        logic       irq;   // expected irq after the edge
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 3'd1, 8'h00, 5'd0,  8'h00, 1'b0, 4'd1},   // R1 enable reg
        '{2'd2, 3'd2, 8'h00, 5'd0,  8'h01, 1'b0, 4'd1},   // R1 ident
        '{2'd2, 3'd5, 8'h00, 5'd0,  8'h60, 1'b0, 4'd1},   // R1 status
        '{2'd1, 3'd1, 8'h0F, 5'd0,  8'h00, 1'b1, 4'd8},   // R8 enable while empty
        '{2'd2, 3'd2, 8'h00, 5'd0,  8'h02, 1'b0, 4'd7},   // R7 ident read retires
        '{2'd2, 3'd1, 8'h00, 5'd0,  8'h0F, 1'b0, 4'd2},   // R2 readback
        '{2'd1, 3'd2, 8'h81, 5'd0,  8'h00, 1'b1, 4'd9},   // R9 FIFO on arms
        '{2'd2, 3'd2, 8'h00, 5'd0,  8'hC2, 1'b0, 4'd6},   // R6 mode bits
        '{2'd1, 3'd2, 8'h81, 5'd0,  8'h00, 1'b0, 4'd9},   // R9 no change, no arm
        '{2'd2, 3'd5, 8'h00, 5'd7,  8'h61, 1'b0, 4'd3},   // R3 below trigger 8
        '{2'd0, 3'd0, 8'h00, 5'd8,  8'h00, 1'b1, 4'd11},  // R11 at trigger 8
        '{2'd2, 3'd2, 8'h00, 5'd8,  8'hC4, 1'b1, 4'd5},   // R5 rx data code
        '{2'd1, 3'd2, 8'hC1, 5'd8,  8'h00, 1'b0, 4'd11},  // R11 trigger 14
        '{2'd0, 3'd0, 8'h00, 5'd14, 8'h00, 1'b1, 4'd11},  // R11 at 14
        '{2'd1, 3'd2, 8'h00, 5'd0,  8'h00, 1'b1, 4'd9},   // R9 FIFO off arms
        '{2'd1, 3'd0, 8'h55, 5'd0,  8'h00, 1'b0, 4'd7},   // R7 data write retires
        '{2'd0, 3'd0, 8'h00, 5'd1,  8'h00, 1'b1, 4'd11},  // R11 non-FIFO one byte
        '{2'd2, 3'd2, 8'h00, 5'd1,  8'h04, 1'b1, 4'd6},   // R6 non-FIFO bits 00
        '{2'd0, 3'd0, 8'h00, 5'd0,  8'h00, 1'b0, 4'd11}   // R11 empty
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with read data captured.
    task automatic access(input logic [1:0] op, input logic [2:0] a,
                          input logic [7:0] d, output logic [7:0] r);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = (op == 2'd1);
        reg_rd    = (op == 2'd2);
        #1 r = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        access(2'd1, a, d, dummy);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] r);
        access(2'd2, a, 8'h00, r);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            rx_count = VECS[i].rxc;
            access(VECS[i].op, VECS[i].addr, VECS[i].wd, rv);
            if (VECS[i].op == 2'd2)
                check($sformatf("R%0d data vec%0d", VECS[i].req, i), rv, VECS[i].exp);
            check($sformatf("R%0d irq vec%0d", VECS[i].req, i), {7'b0, irq}, {7'b0, VECS[i].irq});
        end

        // R3 / R4: framing error in FIFO mode.
        wr(3'd1, 8'h04);
        wr(3'd2, 8'h81);
        tx_empty = 1'b0;
        rx_count = 1;
        ev_frame_err = 1'b1;
        @(negedge clk);
        ev_frame_err = 1'b0;
        check("R3 irq after framing", {7'b0, irq}, 8'h01);
        rd(3'd2, rv); check("R5 line status code", rv, 8'hC6);
        rd(3'd5, rv); check("R3 status 0xA9", rv, 8'hA9);
        check("R4 irq low after status read", {7'b0, irq}, 8'h00);
        rd(3'd5, rv); check("R4 sticky cleared", rv, 8'h21);

        // R10: FIFO off clears errors.
        ev_parity_err = 1'b1;
        @(negedge clk);
        ev_parity_err = 1'b0;
        check("R10 irq before FIFO off", {7'b0, irq}, 8'h01);
        wr(3'd2, 8'h00);
        check("R10 irq after FIFO off", {7'b0, irq}, 8'h00);
        rd(3'd5, rv); check("R10 status after FIFO off", rv, 8'h21);

        // R5: walk every source in rank order.
        wr(3'd1, 8'h0F);
        wr(3'd2, 8'h01);
        rx_timeout = 1'b1;
        modem_event = 1'b1;
        rd(3'd2, rv); check("R5 rx data over others", rv, 8'hC4);
        ev_overrun = 1'b1;
        @(negedge clk);
        ev_overrun = 1'b0;
        rd(3'd2, rv); check("R5 line status highest", rv, 8'hC6);
        rd(3'd5, rv); check("R3 overrun only", rv, 8'h23);
        rd(3'd2, rv); check("R5 back to rx data", rv, 8'hC4);
        rx_count = 0;
        rd(3'd2, rv); check("R13 timeout in FIFO mode", rv, 8'hCC);
        rx_timeout = 1'b0;
        rd(3'd2, rv); check("R5 transmit-empty code", rv, 8'hC2);
        rd(3'd2, rv); check("R5 modem lowest", rv, 8'hC0);
        modem_event = 1'b0;
        rd(3'd2, rv); check("R6 nothing pending", rv, 8'hC1);
        check("R6 irq low", {7'b0, irq}, 8'h00);

        // R13: timeout ignored outside FIFO mode.
        wr(3'd1, 8'h01);
        rx_timeout = 1'b1;
        wr(3'd2, 8'h00);
        check("R13 irq with FIFO off", {7'b0, irq}, 8'h00);
        rd(3'd2, rv); check("R13 ident with FIFO off", rv, 8'h01);
        wr(3'd2, 8'h01);
        rd(3'd2, rv); check("R13 timeout after FIFO on", rv, 8'hCC);
        rx_timeout = 1'b0;

        // R12 / R9: clear strobes.
        wr(3'd2, 8'h05);
        check("R12 tx clear pulse", {6'b0, rx_fifo_clr, tx_fifo_clr}, 8'h01);
        @(negedge clk);
        check("R12 tx clear one cycle", {6'b0, rx_fifo_clr, tx_fifo_clr}, 8'h00);
        wr(3'd2, 8'h00);
        check("R9 mode change clears both", {6'b0, rx_fifo_clr, tx_fifo_clr}, 8'h03);
        wr(3'd2, 8'h02);
        check("R12 rx clear pulse", {6'b0, rx_fifo_clr, tx_fifo_clr}, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule